// File: doc/BRIEF.md
# Two-Wire Converter Host Controller

This block is the host-side master for a serial analog-to-digital converter that shares one clock line and one data line with its host. On a conversion request it pulls the clock line low once to start the converter. It then issues the extra falling edges that lower the resolution from 16 bits to the requested value. Next it holds the clock high until the data line shows that the conversion is complete. Finally it clocks the result in, sign bit first, and presents it as a sign-extended 16-bit word with a one-cycle strobe.

A second request, resynchronise, recovers a host that has lost track of the converter, for example after a watchdog reset. The block toggles the clock and samples the data line at the end of each high, low and high phase. It classifies each triple of samples. When the triple shows that the last falling edge started a new conversion, the block pulses `sync_found` and continues as for a full 16-bit conversion. Clock phase widths are parameters in system clocks and must each exceed the converter's worst-case glitch-rejection width of 750 ns.

States: IDLE (clock high, waiting for a request), START_LO (low phase of the start edge), RED_HI / RED_LO (one pulse for each resolution reduction), WAIT (clock high until the data line goes low and then high, or a timeout), RD_LO / RD_HI (one pulse for each result bit), SYNC_HI / SYNC_LO (resynchronisation toggling). Transitions: IDLE→SYNC_HI on a resync request; IDLE→START_LO on a conversion request; START_LO→RED_HI or →WAIT when no reductions remain; RED_HI→RED_LO; RED_LO→RED_HI or →WAIT; WAIT→RD_LO on completion; WAIT→IDLE on timeout; RD_LO→RD_HI; RD_HI→RD_LO or →IDLE after the last bit; SYNC_HI→SYNC_LO; SYNC_HI→WAIT on the start signature; SYNC_HI→IDLE at the edge limit; SYNC_LO→SYNC_HI.

Top module: `adc2w_host`

## Requirements
- R1: After reset, `adc_clk` is 1 and `busy`, `result_valid`, `sync_found` and `timeout_err` are 0.
- R2: A conversion request in IDLE gives one start falling edge, followed by exactly 16 − r reduction pulses. Here r is `res_req` clamped to 10..16: values below 10 act as 10 and values above 16 act as 16.
- R3: After the start and reduction edges, `adc_clk` stays high and no readout edge is issued until the data line has been seen low and then high.
- R4: The readout gives r falling edges. The bit sampled in the last cycle of each low phase is taken MSB first, so the first bit is the sign. A complete convert-and-read cycle has 17 falling edges.
- R5: `result` holds the r-bit two's complement word in its low r bits, sign-extended to 16 bits. `result_valid` pulses for one cycle, and `busy` is 0 in that same cycle.
- R6: If the data line has not risen within `TIMEOUT_CYC` cycles of entering WAIT, `timeout_err` pulses for one cycle. No result is produced, and the block returns to IDLE with `adc_clk` high.
- R7: `conv_req` is ignored while `busy` is 1 and adds no clock edge.
- R8: In resync mode, the data samples at the end of a high, a low and a high phase that read 1,1,0 pulse `sync_found`. The block then waits and reads a full 16-bit word.
- R9: The triples 0,1,0 (reduction) and x,0,0 (transfer or busy) do not end resync. After `SYNC_LIMIT` falling edges without the start signature, `timeout_err` pulses and the block returns to IDLE.
- R10: When `sync_req` and `conv_req` are both high in IDLE, the resync request wins.
- R11: Every low phase of `adc_clk` lasts exactly `LO_CYC` cycles, and every high phase between edges lasts at least `HI_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_req | input | 1 | Start a conversion (sampled in IDLE) |
| sync_req | input | 1 | Start resynchronisation (sampled in IDLE) |
| res_req | input | 5 | Requested resolution in bits, clamped to 10..16 |
| adc_dat | input | 1 | Data line from the converter |
| adc_clk | output | 1 | Clock line to the converter, idles high |
| busy | output | 1 | High whenever the controller is not in IDLE |
| result | output | 16 | Sign-extended conversion result |
| result_valid | output | 1 | One-cycle strobe for `result` |
| sync_found | output | 1 | One-cycle pulse when resync sees the start signature |
| timeout_err | output | 1 | One-cycle pulse on conversion timeout or resync limit |

## Verification
A wrong reduction count shows up at the ports within one conversion. The converter then returns a word of a different length, so the falling-edge total differs from 17 and the sign extension lands on the wrong bit. A state that leaves WAIT too early issues readout edges while the converter is still busy, and the bench sees this directly as an edge count of more than one in the timeout case. A misclassified resync triple shows either as a `sync_found` pulse during the lost-track readout or as an edge count other than the preset remaining bits plus 17.

// File: rtl/adc2w_pkg.sv
package adc2w_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START_LO,
        S_RED_HI,
        S_RED_LO,
        S_WAIT,
        S_RD_LO,
        S_RD_HI,
        S_SYNC_HI,
        S_SYNC_LO
    } host_state_e;

    // Classification of a high/low/high data-line sample triple
    typedef enum logic [1:0] {
        SIG_NONE,
        SIG_START,
        SIG_REDUCE,
        SIG_XFER_BUSY
    } sig_e;

endpackage

// File: rtl/adc2w_phase_timer.sv
module adc2w_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Cycles spent in the current state; zero on the first cycle of a state
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= '0;
        end else if (count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/adc2w_sig_decode.sv
module adc2w_sig_decode
    import adc2w_pkg::*;
(
    input  logic s_hi0,
    input  logic s_lo,
    input  logic s_hi1,
    output sig_e sig
);
    always_comb begin
        unique case ({s_hi0, s_lo, s_hi1})
            3'b110:         sig = SIG_START;
            3'b010:         sig = SIG_REDUCE;
            3'b000, 3'b100: sig = SIG_XFER_BUSY;
            default:        sig = SIG_NONE;
        endcase
    end
endmodule

// File: rtl/adc2w_sign_ext.sv
module adc2w_sign_ext #(
    parameter int W    = 16,
    parameter int NB_W = 5
) (
    input  logic [W-1:0]    raw,
    input  logic [NB_W-1:0] nbits,
    output logic [W-1:0]    ext
);
    logic sign;

    always_comb begin
        sign = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (NB_W'(i + 1) == nbits) sign = raw[i];
        end
        for (int i = 0; i < W; i++) begin
            ext[i] = (NB_W'(i) < nbits) ? raw[i] : sign;
        end
    end
endmodule

// File: rtl/adc2w_host.sv
module adc2w_host
    import adc2w_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int MIN_RES     = 10,
    parameter int LO_CYC      = 40,
    parameter int HI_CYC      = 40,
    parameter int TIMEOUT_CYC = 50000,
    parameter int SYNC_LIMIT  = 40
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            conv_req,
    input  logic                            sync_req,
    input  logic [$clog2(WORD_W+1)-1:0]     res_req,
    input  logic                            adc_dat,
    output logic                            adc_clk,
    output logic                            busy,
    output logic [WORD_W-1:0]               result,
    output logic                            result_valid,
    output logic                            sync_found,
    output logic                            timeout_err
);
    localparam int RES_W   = $clog2(WORD_W + 1);
    localparam int MAX_RED = WORD_W - MIN_RES;
    localparam int TMR_TOP = (TIMEOUT_CYC > LO_CYC + HI_CYC) ? TIMEOUT_CYC : LO_CYC + HI_CYC;
    localparam int TMR_W   = $clog2(TMR_TOP + 1);
    localparam int EDGE_W  = $clog2(SYNC_LIMIT + 1);
    localparam int RUN_CAP = LO_CYC + HI_CYC;
    localparam int RUN_W   = $clog2(RUN_CAP + 1);

    localparam logic [TMR_W-1:0]  LO_LAST  = TMR_W'(LO_CYC - 1);
    localparam logic [TMR_W-1:0]  HI_LAST  = TMR_W'(HI_CYC - 1);
    localparam logic [TMR_W-1:0]  TMO_LAST = TMR_W'(TIMEOUT_CYC - 1);
    localparam logic [RES_W-1:0]  RES_MIN  = RES_W'(MIN_RES);
    localparam logic [RES_W-1:0]  RES_FULL = RES_W'(WORD_W);
    localparam logic [EDGE_W-1:0] EDGE_MAX = EDGE_W'(SYNC_LIMIT);

    host_state_e       state_q, state_d;
    logic [TMR_W-1:0]  tmr;
    logic [1:0]        dat_sync;
    logic              dat_s;
    logic [RES_W-1:0]  res_eff, res_q, red_left, bits_left;
    logic [WORD_W-1:0] shreg, ext_word;
    logic              armed, samp_a, samp_b, have_b;
    logic [EDGE_W-1:0] edges;
    sig_e              sync_sig;
    logic              lo_end, hi_end, tmo;

    // Two-flop synchroniser on the converter's data line
    always_ff @(posedge clk) begin
        if (!rst_n) dat_sync <= 2'b11;
        else        dat_sync <= {dat_sync[0], adc_dat};
    end
    assign dat_s = dat_sync[1];

    adc2w_phase_timer #(.CNT_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .count   (tmr)
    );

    adc2w_sig_decode u_decode (
        .s_hi0 (samp_a),
        .s_lo  (samp_b),
        .s_hi1 (dat_s),
        .sig   (sync_sig)
    );

    adc2w_sign_ext #(.W(WORD_W), .NB_W(RES_W)) u_sext (
        .raw   (shreg),
        .nbits (res_q),
        .ext   (ext_word)
    );

    assign lo_end = (tmr == LO_LAST);
    assign hi_end = (tmr >= HI_LAST);
    assign tmo    = (tmr == TMO_LAST);

    always_comb begin
        if (res_req < RES_MIN)       res_eff = RES_MIN;
        else if (res_req > RES_FULL) res_eff = RES_FULL;
        else                         res_eff = res_req;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (sync_req)      state_d = S_SYNC_HI;
                else if (conv_req) state_d = S_START_LO;
            end
            S_START_LO: if (lo_end) state_d = (red_left == '0) ? S_WAIT : S_RED_HI;
            S_RED_HI:   if (hi_end) state_d = S_RED_LO;
            S_RED_LO:   if (lo_end) state_d = (red_left == '0) ? S_WAIT : S_RED_HI;
            S_WAIT: begin
                if (tmo)                            state_d = S_IDLE;
                else if (armed && dat_s && hi_end)  state_d = S_RD_LO;
            end
            S_RD_LO:    if (lo_end) state_d = S_RD_HI;
            S_RD_HI:    if (hi_end) state_d = (bits_left == '0) ? S_IDLE : S_RD_LO;
            S_SYNC_HI: begin
                if (hi_end) begin
                    if (have_b && sync_sig == SIG_START) state_d = S_WAIT;
                    else if (edges == EDGE_MAX)          state_d = S_IDLE;
                    else                                 state_d = S_SYNC_LO;
                end
            end
            S_SYNC_LO:  if (lo_end) state_d = S_SYNC_HI;
            default:    state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_clk      <= 1'b1;
            result       <= '0;
            result_valid <= 1'b0;
            sync_found   <= 1'b0;
            timeout_err  <= 1'b0;
            res_q        <= RES_FULL;
            red_left     <= '0;
            bits_left    <= '0;
            shreg        <= '0;
            armed        <= 1'b0;
            samp_a       <= 1'b1;
            samp_b       <= 1'b1;
            have_b       <= 1'b0;
            edges        <= '0;
        end else begin
            adc_clk      <= !(state_d inside {S_START_LO, S_RED_LO, S_RD_LO, S_SYNC_LO});
            result_valid <= (state_q == S_RD_HI) && (state_d == S_IDLE);
            sync_found   <= (state_q == S_SYNC_HI) && (state_d == S_WAIT);
            timeout_err  <= (state_q inside {S_WAIT, S_SYNC_HI}) && (state_d == S_IDLE);

            unique case (state_q)
                S_IDLE: begin
                    if (sync_req) begin
                        res_q  <= RES_FULL;
                        edges  <= '0;
                        have_b <= 1'b0;
                    end else if (conv_req) begin
                        res_q    <= res_eff;
                        red_left <= RES_FULL - res_eff;
                    end
                end
                S_START_LO, S_RED_LO: if (state_d == S_WAIT) armed <= 1'b0;
                S_RED_HI: if (state_d == S_RED_LO) red_left <= red_left - 1'b1;
                S_WAIT: begin
                    if (!dat_s) armed <= 1'b1;
                    if (state_d == S_RD_LO) begin
                        bits_left <= res_q;
                        shreg     <= '0;
                    end
                end
                S_RD_LO: if (lo_end) begin
                    shreg     <= {shreg[WORD_W-2:0], dat_s};
                    bits_left <= bits_left - 1'b1;
                end
                S_RD_HI: if (state_d == S_IDLE) result <= ext_word;
                S_SYNC_HI: if (hi_end) begin
                    samp_a <= dat_s;
                    if (state_d == S_SYNC_LO) edges <= edges + 1'b1;
                    if (state_d == S_WAIT)    armed <= 1'b1;
                end
                S_SYNC_LO: if (lo_end) begin
                    samp_b <= dat_s;
                    have_b <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy = (state_q != S_IDLE);

    // ---------------- assertions ----------------
    logic             clk_d;
    logic [RUN_W-1:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_d <= 1'b1;
            run   <= RUN_W'(RUN_CAP);
        end else begin
            clk_d <= adc_clk;
            if (adc_clk != clk_d)            run <= RUN_W'(1);
            else if (run != RUN_W'(RUN_CAP)) run <= run + 1'b1;
        end
    end

    p_low_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_clk && !clk_d) |-> (run == RUN_W'(LO_CYC)));

    p_high_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_clk && clk_d) |-> (run >= RUN_W'(HI_CYC)));

    p_red_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        red_left <= RES_W'(MAX_RED));

    p_wait_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && !armed) |=> (state_q != S_RD_LO));

    p_wait_clk_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT) |-> adc_clk);

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    p_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> !busy);

    p_err_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (!result_valid && !busy && adc_clk));

    p_start_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_START_LO) |-> ($past(state_q) inside {S_IDLE, S_START_LO}));

    p_found_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_found |-> (state_q == S_WAIT && res_q == RES_FULL));

    p_sync_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        edges <= EDGE_MAX);

endmodule

// File: tb/adc2w_host_test.sv
module adc2w_host_test;
    localparam int W      = 16;
    localparam int LO     = 40;
    localparam int HI     = 40;
    localparam int TMO    = 2000;
    localparam int SLIM   = 20;
    localparam int WIN    = 700;
    localparam int CONV_T = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_req = 1'b0;
    logic        sync_req = 1'b0;
    logic [4:0]  res_req = 5'd16;
    logic        adc_dat;
    logic        adc_clk, busy, result_valid, sync_found, timeout_err;
    logic [W-1:0] result;

    always #10 clk = ~clk;

    adc2w_host #(.WORD_W(W), .MIN_RES(10), .LO_CYC(LO), .HI_CYC(HI),
                 .TIMEOUT_CYC(TMO), .SYNC_LIMIT(SLIM)) uut (
        .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .sync_req(sync_req),
        .res_req(res_req), .adc_dat(adc_dat), .adc_clk(adc_clk), .busy(busy),
        .result(result), .result_valid(result_valid), .sync_found(sync_found),
        .timeout_err(timeout_err));

    // ---------------- converter model ----------------
    typedef enum {M_IDLE, M_CONV, M_DONE, M_READ} m_e;
    m_e          mst;
    int          mt, mred, mbits;
    logic [15:0] mword;
    logic        ck_q;
    logic [15:0] nxt_sample = 16'h0;
    bit          stuck_conv = 1'b0, stuck_low = 1'b0, pre_req = 1'b0;
    m_e          pre_st = M_IDLE;
    int          pre_bits = 0;
    logic [15:0] pre_word = 16'h0;

    always @(negedge clk) begin
        logic fall, rise;
        fall = ck_q && !adc_clk;
        rise = !ck_q && adc_clk;
        if (!rst_n) begin
            mst <= M_IDLE; adc_dat <= 1'b1; ck_q <= 1'b1;
            mt <= 0; mred <= 0; mbits <= 0; mword <= '0;
        end else if (pre_req) begin
            mst <= pre_st; mbits <= pre_bits; mword <= pre_word;
            adc_dat <= (pre_st == M_READ) ? 1'b0 : 1'b1;
            ck_q <= adc_clk;
        end else begin
            ck_q <= adc_clk;
            if (stuck_low) adc_dat <= 1'b0;
            else case (mst)
                M_IDLE: begin
                    adc_dat <= 1'b1;
                    if (fall) begin mst <= M_CONV; mt <= 0; mred <= 0; end
                end
                M_CONV: begin
                    mt <= mt + 1;
                    if (fall && mt < WIN && mred < 6) begin
                        mred <= mred + 1; adc_dat <= 1'b1;
                    end else if (rise) begin
                        adc_dat <= 1'b0;
                    end else if (mt >= CONV_T && adc_clk && !stuck_conv) begin
                        mst <= M_DONE; adc_dat <= 1'b1;
                        mbits <= 16 - mred; mword <= nxt_sample;
                    end
                end
                M_DONE: if (fall) begin
                    mst <= M_READ; mbits <= mbits - 1; adc_dat <= mword[mbits-1];
                end
                M_READ: begin
                    if (fall && mbits > 0) begin
                        mbits <= mbits - 1; adc_dat <= mword[mbits-1];
                    end else if (rise && mbits == 0) begin
                        mst <= M_IDLE; adc_dat <= 1'b1;
                    end
                end
                default: mst <= M_IDLE;
            endcase
        end
    end

    // ---------------- edge and pulse monitors ----------------
    int   falls, prun, bad_lo, bad_hi, n_valid, n_found, n_err;
    logic ck2;

    always @(negedge clk) begin
        if (!rst_n) begin
            ck2 <= 1'b1; falls <= 0; prun <= 1000; bad_lo <= 0; bad_hi <= 0;
            n_valid <= 0; n_found <= 0; n_err <= 0;
        end else begin
            ck2 <= adc_clk;
            if (ck2 != adc_clk) begin
                prun <= 1;
                if (!ck2 && prun != LO) bad_lo <= bad_lo + 1;
                if (ck2 && prun < HI)   bad_hi <= bad_hi + 1;
                if (ck2) falls <= falls + 1;
            end else begin
                prun <= prun + 1;
            end
            if (result_valid) n_valid <= n_valid + 1;
            if (sync_found)   n_found <= n_found + 1;
            if (timeout_err)  n_err   <= n_err + 1;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct { logic [15:0] word; int red; bit chk; } exp_t;
    exp_t q[$];
    int   base = 0;
    int   mon_chk = 0, mon_fail = 0;

    always @(negedge clk) begin
        if (rst_n && result_valid) begin
            exp_t it;
            mon_chk++;
            if (q.size() == 0) begin
                mon_fail++;
                $display("FAIL R5 unexpected result actual=%h expected=none", result);
            end else begin
                it = q.pop_front();
                if (result !== it.word) begin
                    mon_fail++;
                    $display("FAIL R5/R4 result actual=%h expected=%h", result, it.word);
                end
                mon_chk++;
                if (busy !== 1'b0) begin
                    mon_fail++;
                    $display("FAIL R5 busy at valid actual=%b expected=0", busy);
                end
                if (it.chk) begin
                    mon_chk += 2;
                    if (falls - base != 17) begin
                        mon_fail++;
                        $display("FAIL R4 falling edges actual=%0d expected=17", falls - base);
                    end
                    if (mred != it.red) begin
                        mon_fail++;
                        $display("FAIL R2 reductions actual=%0d expected=%0d", mred, it.red);
                    end
                end
            end
        end
    end

    // ---------------- driver ----------------
    int nchk = 0, nfail = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] sext(input logic [15:0] v, input int r);
        logic [15:0] t;
        t = v << (16 - r);
        return 16'($signed(t) >>> (16 - r));
    endfunction

    task automatic wait_count(ref int cnt, input int start_val);
        int guard = 0;
        while (cnt == start_val && guard < 20000) begin
            @(negedge clk); guard++;
        end
    endtask

    task automatic preset(input m_e st, input int bits, input logic [15:0] w);
        @(posedge clk);
        pre_st = st; pre_bits = bits; pre_word = w; pre_req = 1'b1;
        @(posedge clk);
        pre_req = 1'b0;
    endtask

    task automatic do_conv(input int res_in, input logic [15:0] smp, input int r_eff,
                           input bit mid_start);
        int v0;
        exp_t it;
        it.word = sext(smp, r_eff); it.red = 16 - r_eff; it.chk = 1'b1;
        nxt_sample = smp;
        q.push_back(it);
        v0 = n_valid;
        @(negedge clk);
        base = falls;
        res_req = 5'(res_in); conv_req = 1'b1;
        @(negedge clk);
        conv_req = 1'b0;
        if (mid_start) begin
            repeat (300) @(negedge clk);
            conv_req = 1'b1;
            @(negedge clk);
            conv_req = 1'b0;
        end
        wait_count(n_valid, v0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        check(adc_clk == 1'b1, "R1 adc_clk", adc_clk, 1);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(result_valid == 1'b0 && sync_found == 1'b0, "R1 strobes", {result_valid, sync_found}, 0);
        check(timeout_err == 1'b0, "R1 timeout_err", timeout_err, 0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);

        // R2 R4 R5: several resolutions, including clamped requests
        do_conv(16, 16'h8001, 16, 1'b0);
        do_conv(10, 16'h0201, 10, 1'b0);
        do_conv(13, 16'h0ABC, 13, 1'b0);
        do_conv(5,  16'h01FF, 10, 1'b0);   // R2 clamp low
        do_conv(20, 16'h7FFF, 16, 1'b0);   // R2 clamp high

        // R7: request during busy is ignored
        begin
            int f0;
            do_conv(12, 16'h0800, 12, 1'b1);
            f0 = falls;
            repeat (200) @(negedge clk);
            check(falls == f0, "R7 no extra edge", falls - f0, 0);
            check(busy == 1'b0, "R7 idle after", busy, 0);
        end

        // R6 timeout, R3 no readout edge while waiting
        begin
            int v0, e0, cyc;
            @(posedge clk); stuck_conv = 1'b1;
            v0 = n_valid; e0 = n_err; cyc = 0;
            @(negedge clk);
            base = falls;
            res_req = 5'd16; conv_req = 1'b1;
            @(negedge clk); conv_req = 1'b0;
            while (n_err == e0 && cyc < 10000) begin @(negedge clk); cyc++; end
            check(n_err == e0 + 1, "R6 timeout pulse", n_err - e0, 1);
            check(cyc >= TMO && cyc <= TMO + LO + 8, "R6 timeout delay", cyc, TMO + LO);
            check(n_valid == v0, "R6 no result", n_valid - v0, 0);
            check(adc_clk == 1'b1 && busy == 1'b0, "R6 idle state", {adc_clk, busy}, 2);
            check(falls - base == 1, "R3 only start edge", falls - base, 1);
            @(posedge clk); stuck_conv = 1'b0;
            preset(M_IDLE, 0, 16'h0);
            repeat (50) @(negedge clk);
        end

        // R8 resync from idle converter
        begin
            int f0, v0;
            exp_t it;
            nxt_sample = 16'hC3A5;
            it.word = 16'hC3A5; it.red = 0; it.chk = 1'b0;
            q.push_back(it);
            f0 = n_found; v0 = n_valid;
            @(negedge clk); sync_req = 1'b1;
            @(negedge clk); sync_req = 1'b0;
            wait_count(n_valid, v0);
            check(n_found == f0 + 1, "R8 found from idle", n_found - f0, 1);
            repeat (50) @(negedge clk);
        end

        // R8 R9 resync while converter is mid-readout
        begin
            int f0, v0;
            exp_t it;
            preset(M_READ, 5, 16'h0016);
            nxt_sample = 16'h1234;
            it.word = 16'h1234; it.red = 0; it.chk = 1'b0;
            q.push_back(it);
            f0 = n_found; v0 = n_valid;
            @(negedge clk);
            base = falls;
            sync_req = 1'b1;
            @(negedge clk); sync_req = 1'b0;
            wait_count(n_valid, v0);
            check(n_found == f0 + 1, "R8 found once mid-read", n_found - f0, 1);
            check(falls - base == 22, "R9 readout triples skipped", falls - base, 22);
            repeat (50) @(negedge clk);
        end

        // R10 resync wins over conversion
        begin
            int f0, v0;
            exp_t it;
            nxt_sample = 16'hF00D;
            it.word = 16'hF00D; it.red = 0; it.chk = 1'b0;
            q.push_back(it);
            f0 = n_found; v0 = n_valid;
            @(negedge clk);
            res_req = 5'd10; sync_req = 1'b1; conv_req = 1'b1;
            @(negedge clk); sync_req = 1'b0; conv_req = 1'b0;
            wait_count(n_valid, v0);
            check(n_found == f0 + 1, "R10 resync chosen", n_found - f0, 1);
            repeat (50) @(negedge clk);
        end

        // R9 resync limit with a data line stuck low
        begin
            int f0, e0;
            @(posedge clk); stuck_low = 1'b1;
            f0 = n_found; e0 = n_err;
            @(negedge clk);
            base = falls;
            sync_req = 1'b1;
            @(negedge clk); sync_req = 1'b0;
            wait_count(n_err, e0);
            check(n_err == e0 + 1, "R9 limit error", n_err - e0, 1);
            check(n_found == f0, "R9 no signature", n_found - f0, 0);
            check(falls - base == SLIM, "R9 edge limit", falls - base, SLIM);
            @(posedge clk); stuck_low = 1'b0;
            preset(M_IDLE, 0, 16'h0);
            repeat (20) @(negedge clk);
        end

        // R11 phase widths over the whole run; scoreboard drained
        check(bad_lo == 0, "R11 low phase width", bad_lo, 0);
        check(bad_hi == 0, "R11 high phase width", bad_hi, 0);
        check(q.size() == 0, "R5 all results seen", q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures",
                 nchk + mon_chk, nfail + mon_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 nchk + mon_chk + 1, nfail + mon_fail + 1);
        $finish;
    end
endmodule